// File: doc/BRIEF.md
# Packet Receive Bus Source

This block is the device end of a 32-bit packet receive bus. Each port has a small word queue that a local writer fills with packet words. A word carries 32 data bits, start and end markers, an error flag and a 2-bit byte-count code. The link layer pulls words off a single shared bus by holding an active-low read enable low. The block chooses which port to serve and steps through that port's packet. When it starts on a different port, it first places the port number on the bus as an address word.

Every bus output is a register that loads on a rising clock edge. An edge at which the read enable is high leaves all outputs exactly as they were. An edge at which it is low advances the bus by one step: an address word, a payload word, or a cycle with the valid strobe low when there is nothing to send. A parity bit over the 32 data bits goes with each step. Its sense is odd unless the even-parity setting is raised.

Top module: `pos_rx_source`

## Requirements
- R1: While reset is asserted, and at the first edge after it is released, every bus output (data, parity, modulo, start, end, error, address strobe, valid) is 0.
- R2: At an edge where `rd_enb_n` is sampled high, no queue word is consumed and every bus output keeps its value.
- R3: At an edge where `rd_enb_n` is sampled low and a word from the port being served is available, that word is consumed and placed on the outputs at that edge, with `rx_val` high and `rx_addr` low.
- R4: An address word is sent when the port about to be served differs from the last port addressed, or when no port has been addressed since reset. It has `rx_addr`=1, `rx_val`=1, the port number in the low data bits, zeros in the upper data bits, and start, end, error and modulo all 0. It consumes no queue word.
- R5: On every step taken with the enable low, `rx_par` is chosen so that the 33 bits {data, parity} contain an odd number of ones when `cfg_even_par`=0, and an even number when it is 1.
- R6: `rx_mod` is the stored code only on an end word, where 0 means 4 valid bytes, 1 means 3, 2 means 2 and 3 means 1. On every other word it is 0.
- R7: At an edge with the enable low and no word to send, `rx_val` and `rx_addr` go low, no word is consumed, and the other outputs hold.
- R8: Outside a packet, the next port is the first non-empty queue found by scanning upward from the port after the last one served, wrapping around. The last-served port resets to 0, so the first scan begins at port 1.
- R9: After a port's start word, every payload word up to and including its end word comes from that same port. If that queue runs dry, the block waits on it (R7) and does not switch.
- R10: Each port's words come out in write order with their start, end and error flags unchanged.
- R11: `fifo_full[p]` is high exactly when port p's queue holds DEPTH words. A write into a full queue is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock; all outputs launch on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write one word into the queue selected by wr_port |
| wr_port | input | PW | Queue index for the write |
| wr_data | input | 32 | Data word to store |
| wr_sop | input | 1 | Word starts a packet |
| wr_eop | input | 1 | Word ends a packet |
| wr_err | input | 1 | Packet error flag |
| wr_mod | input | 2 | Byte-count code for an end word |
| fifo_full | output | NPORT | Per-queue full flag |
| rd_enb_n | input | 1 | Active-low read enable from the link layer |
| cfg_even_par | input | 1 | 1 selects even parity, 0 odd |
| rx_data | output | 32 | Payload word or port address |
| rx_par | output | 1 | Parity over rx_data |
| rx_mod | output | 2 | Byte-count code |
| rx_sop | output | 1 | Start of packet |
| rx_eop | output | 1 | End of packet |
| rx_err | output | 1 | Error flag on the packet |
| rx_addr | output | 1 | Address-word strobe |
| rx_val | output | 1 | Outputs carry a meaningful step |

## Verification
Every bus result appears at the same rising edge that samples the enable. The bench drives inputs on the falling edge, advances its reference model once for that coming edge, and compares the outputs at the next falling edge, half a cycle after they load. A write counts in a queue from the edge that takes it. A read decision at that edge therefore sees the queue as it stood before the write, and the model pops before it pushes. `fifo_full` is checked at the same falling edge against the model's count after that edge.

// File: rtl/pos_rx_pkg.sv
package pos_rx_pkg;
    localparam int DW = 32;
    localparam int MW = 2;

    typedef struct packed {
        logic [DW-1:0] data;
        logic          sop;
        logic          eop;
        logic          err;
        logic [MW-1:0] mod;
    } word_t;

    // parity bit that makes {data, bit} odd (even_sel=0) or even (even_sel=1)
    function automatic logic par_bit(input logic [DW-1:0] d, input logic even_sel);
        return (^d) ^ ~even_sel;
    endfunction
endpackage

// File: rtl/pos_rx_fifo.sv
module pos_rx_fifo
    import pos_rx_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  push,
    input  word_t din,
    input  logic  pop,
    output word_t dout,
    output logic  empty,
    output logic  full
);
    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
        logic [CW-1:0] count;
    } fst_t;

    fst_t  fs_q, fs_d;
    word_t mem_q [DEPTH];
    logic  do_push, do_pop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (fs_q.count == '0);
    assign full    = (fs_q.count == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem_q[fs_q.rptr];

    always_comb begin
        fs_d = fs_q;
        if (do_push) fs_d.wptr = bump(fs_q.wptr);
        if (do_pop)  fs_d.rptr = bump(fs_q.rptr);
        case ({do_push, do_pop})
            2'b10:   fs_d.count = fs_q.count + 1'b1;
            2'b01:   fs_d.count = fs_q.count - 1'b1;
            default: fs_d.count = fs_q.count;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fs_q <= '0;
        else        fs_q <= fs_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[fs_q.wptr] <= din;
    end
endmodule

// File: rtl/pos_rx_rr.sv
module pos_rx_rr #(
    parameter int NPORT = 4,
    localparam int PW = (NPORT > 1) ? $clog2(NPORT) : 1
) (
    input  logic [NPORT-1:0] req,
    input  logic [PW-1:0]    last,
    output logic             any,
    output logic [PW-1:0]    pick
);
    always_comb begin
        any  = 1'b0;
        pick = '0;
        for (int k = 1; k <= NPORT; k++) begin
            int idx;
            idx = (int'(last) + k) % NPORT;
            if (!any && req[idx]) begin
                any  = 1'b1;
                pick = PW'(idx);
            end
        end
    end
endmodule

// File: rtl/pos_rx_source.sv
module pos_rx_source
    import pos_rx_pkg::*;
#(
    parameter int NPORT = 4,
    parameter int DEPTH = 8,
    localparam int PW = (NPORT > 1) ? $clog2(NPORT) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [PW-1:0]    wr_port,
    input  logic [31:0]      wr_data,
    input  logic             wr_sop,
    input  logic             wr_eop,
    input  logic             wr_err,
    input  logic [1:0]       wr_mod,
    output logic [NPORT-1:0] fifo_full,
    input  logic             rd_enb_n,
    input  logic             cfg_even_par,
    output logic [31:0]      rx_data,
    output logic             rx_par,
    output logic [1:0]       rx_mod,
    output logic             rx_sop,
    output logic             rx_eop,
    output logic             rx_err,
    output logic             rx_addr,
    output logic             rx_val
);
    typedef struct packed {
        logic [PW-1:0] port;
        logic          addr_done;
        logic          in_pkt;
        logic [DW-1:0] data;
        logic          par;
        logic [MW-1:0] mod;
        logic          sop;
        logic          eop;
        logic          err;
        logic          addr;
        logic          val;
    } st_t;

    st_t   st_q, st_d;
    word_t in_word;
    word_t head [NPORT];
    logic  [NPORT-1:0] empty_v;
    logic  [NPORT-1:0] pop_v;
    logic  any_req;
    logic  [PW-1:0] rr_pick;
    logic  pop_d;
    logic  [PW-1:0] pop_port;

    assign in_word = '{data: wr_data, sop: wr_sop, eop: wr_eop, err: wr_err, mod: wr_mod};

    for (genvar g = 0; g < NPORT; g++) begin : g_q
        assign pop_v[g] = pop_d && (pop_port == PW'(g));
        pos_rx_fifo #(.DEPTH(DEPTH)) u_q (
            .clk  (clk),
            .rst_n(rst_n),
            .push (wr_en && (wr_port == PW'(g))),
            .din  (in_word),
            .pop  (pop_v[g]),
            .dout (head[g]),
            .empty(empty_v[g]),
            .full (fifo_full[g])
        );
    end

    pos_rx_rr #(.NPORT(NPORT)) u_rr (
        .req (~empty_v),
        .last(st_q.port),
        .any (any_req),
        .pick(rr_pick)
    );

    function automatic st_t load_word(input st_t s, input word_t w, input logic ev);
        st_t r;
        r        = s;
        r.data   = w.data;
        r.sop    = w.sop;
        r.eop    = w.eop;
        r.err    = w.err;
        r.mod    = w.eop ? w.mod : '0;
        r.addr   = 1'b0;
        r.val    = 1'b1;
        r.par    = par_bit(w.data, ev);
        r.in_pkt = !w.eop;
        return r;
    endfunction

    always_comb begin
        st_d     = st_q;
        pop_d    = 1'b0;
        pop_port = st_q.port;
        if (!rd_enb_n) begin
            if (st_q.in_pkt) begin
                if (!empty_v[st_q.port]) begin
                    st_d  = load_word(st_q, head[st_q.port], cfg_even_par);
                    pop_d = 1'b1;
                end else begin
                    st_d.val  = 1'b0;
                    st_d.addr = 1'b0;
                end
            end else if (!any_req) begin
                st_d.val  = 1'b0;
                st_d.addr = 1'b0;
            end else if (!st_q.addr_done || (rr_pick != st_q.port)) begin
                st_d.port            = rr_pick;
                st_d.addr_done       = 1'b1;
                st_d.in_pkt          = 1'b1;
                st_d.data            = '0;
                st_d.data[PW-1:0]    = rr_pick;
                st_d.sop             = 1'b0;
                st_d.eop             = 1'b0;
                st_d.err             = 1'b0;
                st_d.mod             = '0;
                st_d.addr            = 1'b1;
                st_d.val             = 1'b1;
                st_d.par             = par_bit(st_d.data, cfg_even_par);
            end else begin
                st_d     = load_word(st_q, head[rr_pick], cfg_even_par);
                pop_d    = 1'b1;
                pop_port = rr_pick;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rx_data = st_q.data;
    assign rx_par  = st_q.par;
    assign rx_mod  = st_q.mod;
    assign rx_sop  = st_q.sop;
    assign rx_eop  = st_q.eop;
    assign rx_err  = st_q.err;
    assign rx_addr = st_q.addr;
    assign rx_val  = st_q.val;
endmodule

// File: rtl/pos_rx_source_chk.sv
module pos_rx_source_chk #(
    parameter int NPORT = 4,
    localparam int PW = (NPORT > 1) ? $clog2(NPORT) : 1
) (
    input logic        clk,
    input logic        rst_n,
    input logic        rd_enb_n,
    input logic        cfg_even_par,
    input logic [31:0] rx_data,
    input logic        rx_par,
    input logic [1:0]  rx_mod,
    input logic        rx_sop,
    input logic        rx_eop,
    input logic        rx_err,
    input logic        rx_addr,
    input logic        rx_val
);
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_enb_n |=> $stable({rx_data, rx_par, rx_mod, rx_sop, rx_eop, rx_err, rx_addr, rx_val}));

    assert_val_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_val) |-> $past(!rd_enb_n));

    assert_addr_shape_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_addr |-> (rx_val && (rx_data[31:PW] == '0) && !rx_sop && !rx_eop && !rx_err && (rx_mod == 2'b00)));

    assert_parity_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!rd_enb_n) && rx_val) |-> ((^{rx_data, rx_par}) == !$past(cfg_even_par)));

    assert_mod_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_val && !rx_eop) |-> (rx_mod == 2'b00));

    assert_val_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_val) |-> $past(!rd_enb_n));
endmodule

bind pos_rx_source pos_rx_source_chk #(.NPORT(NPORT)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_enb_n    (rd_enb_n),
    .cfg_even_par(cfg_even_par),
    .rx_data     (rx_data),
    .rx_par      (rx_par),
    .rx_mod      (rx_mod),
    .rx_sop      (rx_sop),
    .rx_eop      (rx_eop),
    .rx_err      (rx_err),
    .rx_addr     (rx_addr),
    .rx_val      (rx_val)
);

// File: tb/pos_rx_source_test.sv
`timescale 1ns/1ps
module pos_rx_source_test;
    import pos_rx_pkg::*;
    localparam int NP = 4;
    localparam int DEPTH = 8;
    localparam int PW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [PW-1:0] wr_port = '0;
    logic [31:0] wr_data = '0;
    logic wr_sop = 1'b0, wr_eop = 1'b0, wr_err = 1'b0;
    logic [1:0] wr_mod = '0;
    logic [NP-1:0] fifo_full;
    logic rd_enb_n = 1'b1;
    logic cfg_even_par = 1'b0;
    logic [31:0] rx_data;
    logic rx_par, rx_sop, rx_eop, rx_err, rx_addr, rx_val;
    logic [1:0] rx_mod;

    always #2.5 clk = ~clk;

    pos_rx_source #(.NPORT(NP), .DEPTH(DEPTH)) uut (.*);

    int nvec = 0, nfail = 0, ncyc = 0;

    // reference model
    word_t mq [NP][DEPTH];
    int mh [NP], mc [NP];
    int m_port = 0;
    bit m_done = 0, m_inpkt = 0;
    logic [31:0] e_data = '0;
    logic e_par = 0, e_sop = 0, e_eop = 0, e_err = 0, e_addr = 0, e_val = 0;
    logic [1:0] e_mod = '0;
    int gen_left [NP];

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic check_all(input string tg);
        chk(rx_val  === e_val,  (tg != "") ? tg : "R3/R7", "val",  32'(rx_val),  32'(e_val));
        chk(rx_addr === e_addr, (tg != "") ? tg : "R4",    "addr", 32'(rx_addr), 32'(e_addr));
        chk(rx_data === e_data, (tg != "") ? tg : "R8/R9/R10", "data", rx_data, e_data);
        chk(rx_par  === e_par,  (tg != "") ? tg : "R5",    "par",  32'(rx_par),  32'(e_par));
        chk(rx_mod  === e_mod,  (tg != "") ? tg : "R6",    "mod",  32'(rx_mod),  32'(e_mod));
        chk({rx_sop, rx_eop, rx_err} === {e_sop, e_eop, e_err}, (tg != "") ? tg : "R10",
            "flags", 32'({rx_sop, rx_eop, rx_err}), 32'({e_sop, e_eop, e_err}));
        for (int p = 0; p < NP; p++)
            chk(fifo_full[p] === (mc[p] == DEPTH), "R11", "full", 32'(fifo_full[p]), 32'(mc[p] == DEPTH));
    endtask

    function automatic logic exp_par(input logic [31:0] d, input logic ev);
        int ones = $countones(d);
        // odd mode: total ones odd; even mode: total ones even
        return ev ? logic'(ones % 2) : logic'((ones % 2) == 0);
    endfunction

    task automatic model_pop(input int p);
        word_t w = mq[p][mh[p]];
        mh[p] = (mh[p] + 1) % DEPTH;
        mc[p]--;
        e_data = w.data; e_sop = w.sop; e_eop = w.eop; e_err = w.err;
        e_mod = w.eop ? w.mod : 2'b00;
        e_addr = 0; e_val = 1; e_par = exp_par(w.data, cfg_even_par);
        m_inpkt = !w.eop; m_port = p;
    endtask

    task automatic model_step(input logic enb);
        int found = -1;
        if (enb) return;
        if (m_inpkt) begin
            if (mc[m_port] > 0) model_pop(m_port);
            else begin e_val = 0; e_addr = 0; end
        end else begin
            for (int k = 1; k <= NP; k++)
                if (found < 0 && mc[(m_port + k) % NP] > 0) found = (m_port + k) % NP;
            if (found < 0) begin e_val = 0; e_addr = 0; end
            else if (!m_done || found != m_port) begin
                m_port = found; m_done = 1; m_inpkt = 1;
                e_data = 32'(found); e_sop = 0; e_eop = 0; e_err = 0; e_mod = 0;
                e_addr = 1; e_val = 1; e_par = exp_par(32'(found), cfg_even_par);
            end else model_pop(found);
        end
    endtask

    // one cycle: check outputs, drive, model, advance
    task automatic step(input logic enb, input bit we, input int p, input word_t w, input string tg);
        bit accept;
        check_all(tg);
        rd_enb_n = enb;
        wr_en = we; wr_port = PW'(p);
        wr_data = w.data; wr_sop = w.sop; wr_eop = w.eop; wr_err = w.err; wr_mod = w.mod;
        accept = we && (mc[p] < DEPTH);
        model_step(enb);
        if (accept) begin
            mq[p][(mh[p] + mc[p]) % DEPTH] = w;
            mc[p]++;
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic word_t gen_word(input int p);
        word_t w;
        w.data = $urandom;
        w.mod = 2'($urandom);
        w.err = 0;
        if (gen_left[p] == 0) begin gen_left[p] = 1 + ($urandom % 4); w.sop = 1; end
        else w.sop = 0;
        gen_left[p]--;
        w.eop = (gen_left[p] == 0);
        if (w.eop) w.err = ($urandom % 5 == 0);
        return w;
    endfunction

    function automatic word_t mk(input logic [31:0] d, input bit s, input bit e, input logic [1:0] m);
        word_t w;
        w.data = d; w.sop = s; w.eop = e; w.err = 0; w.mod = m;
        return w;
    endfunction

    initial begin
        word_t z;
        int seed;
        z = '0;
        seed = $urandom(32'd2718);
        for (int p = 0; p < NP; p++) begin mh[p] = 0; mc[p] = 0; gen_left[p] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_all("R1");
        rst_n = 1'b1;
        step(1'b0, 0, 0, z, "R1");   // all queues empty: valid stays low
        check_all("R1");

        // R8: packets in ports 0, 2, 3; scan starts at port 1 -> 2,3,0
        step(1'b1, 1, 0, mk(32'h1111_0000, 1, 1, 2'd1), "R2");
        step(1'b1, 1, 2, mk(32'h2222_0000, 1, 0, 2'd3), "R2");
        step(1'b1, 1, 2, mk(32'h2222_0001, 0, 1, 2'd2), "R2");
        step(1'b1, 1, 3, mk(32'h3333_0000, 1, 1, 2'd0), "R2");
        for (int i = 0; i < 12; i++) step(1'b0, 0, 0, z, "");
        step(1'b1, 0, 0, z, "R2");
        step(1'b1, 0, 0, z, "R2");

        // R9: port 1 packet arrives partially; port 2 must not be taken meanwhile
        step(1'b1, 1, 1, mk(32'hAAAA_0001, 1, 0, 2'd2), "R9");
        step(1'b1, 1, 2, mk(32'hBBBB_0001, 1, 1, 2'd0), "R9");
        for (int i = 0; i < 4; i++) step(1'b0, 0, 0, z, "");
        step(1'b0, 1, 1, mk(32'hAAAA_0002, 0, 1, 2'd3), "");
        for (int i = 0; i < 6; i++) step(1'b0, 0, 0, z, "");

        // R11: overfill port 0 with single-word packets, then drain
        for (int i = 0; i < DEPTH + 3; i++)
            step(1'b1, 1, 0, mk(32'hC0DE_0000 + 32'(i), 1, 1, 2'(i)), "R11");
        for (int i = 0; i < 2 * DEPTH + 4; i++) step(1'b0, 0, 0, z, "");

        // R5: even parity on a few words
        cfg_even_par = 1'b1;
        step(1'b1, 1, 3, mk(32'h0000_0001, 1, 0, 2'd0), "R5");
        step(1'b1, 1, 3, mk(32'hFFFF_FFFF, 0, 1, 2'd1), "R5");
        for (int i = 0; i < 5; i++) step(1'b0, 0, 0, z, "");
        cfg_even_par = 1'b0;

        // random phase
        for (int i = 0; i < 4000; i++) begin
            int p;
            bit we;
            word_t w;
            p = $urandom % NP;
            we = ($urandom % 2 == 0) && (mc[p] < DEPTH);
            w = we ? gen_word(p) : z;
            if ($urandom % 300 == 0) cfg_even_par = ~cfg_even_par;
            step(($urandom % 10) < 3, we, p, w, "");
        end
        for (int i = 0; i < 200; i++) step(1'b0, 0, 0, z, "");
        check_all("");

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    always @(posedge clk) begin
        ncyc++;
        if (ncyc > 150000) begin
            nfail++;
            $display("FAIL watchdog actual=%0d expected<150000 cycles", ncyc);
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end
endmodule